// File: doc/BRIEF.md
# Hashed Page Table Walker

This block finds a page-table entry in a hashed page table held in memory. The caller gives it a 24-bit virtual segment identifier and the low 28 bits of an effective address. The walker hashes them to a group of eight 8-byte entries, placed at the configured table base and limited by the configured table mask. It scans that group one slot at a time. If nothing matches, it scans a second group, found from the bitwise complement of the same hash.

Each entry is two 32-bit words. The first word is always fetched before the second, and the second word is fetched only when the first one matches. On a hit, the walker sets the entry's referenced bit and, for stores, its changed bit, using single-byte writes to the table. It then returns the entry words, the entry's byte address, the translated physical address, and a flag that says whether the caller may keep write permission for the page. Checking permissions is left to the caller.

The memory port carries one request at a time with a valid/ready handshake. Read data comes back later, qualified by its own valid strobe.

Top module: `hpw_walker`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, and `done_valid` and `mem_req_valid` are 0.
- R2: The primary group starts at `tbl_base + ((vsid ^ ea[27:12]) << 6 & tbl_mask)`, with the hash taken at 32 bits. Slots are scanned in order 0 to 7, and slot n starts at the group start plus 8n.
- R3: Word 0 matches when bit 31 (valid) is 1, bit 6 (secondary flag) equals the current pass (0 for primary, 1 for secondary), bits 30:7 equal the VSID, and bits 5:0 equal `ea[27:22]`.
- R4: Word 0 of an entry is read at entry+0. Word 1 is read at entry+4, only after word 0 has returned and only when word 0 matched.
- R5: When the primary group has no match, the group at `tbl_base + ((~hash) << 6 & tbl_mask)` is scanned. When neither group matches, the result has `done_hit` = 0.
- R6: On a hit where word 1 bit 8 (referenced) is 0, one byte write goes to entry+6 with data `((word1 >> 8) & 8'hFF) | 8'h01`. Byte offsets are big-endian, so offset 6 holds word 1 bits 15:8.
- R7: On a hit where word 1 bit 7 (changed) is 0, a store writes one byte to entry+7 with data `(word1 & 8'hFF) | 8'h80`. This write comes after any referenced-bit write. A non-store does no such write and reports `done_write_ok` = 0.
- R8: The result of a hit gives word 0 and word 1 as read from memory, the entry's byte address, `done_phys_addr = {word1[31:12], ea[11:0]}`, and `done_write_ok` = 1 when the changed bit was already set or the access is a store.
- R9: A memory request holds its address, write enable and byte until it is accepted. The walker waits for `mem_rvalid` after each read. While a walk is in progress, `req_ready` is 0.
- R10: `done_valid` is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_base | input | 32 | Byte address of the table |
| tbl_mask | input | 32 | Mask applied to the group offset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker is idle and takes a request |
| req_vsid | input | 24 | Virtual segment identifier |
| req_ea | input | 28 | Effective address bits 27:0 |
| req_store | input | 1 | Access is a store |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = byte write, 0 = word read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wbyte | output | 8 | Byte written when `mem_we` is 1 |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read word |
| done_valid | output | 1 | Result strobe |
| done_hit | output | 1 | Entry found |
| done_word0 | output | 32 | Entry word 0 as read |
| done_word1 | output | 32 | Entry word 1 as read |
| done_entry_addr | output | 32 | Byte address of the entry |
| done_phys_addr | output | 32 | Translated physical address |
| done_write_ok | output | 1 | Caller may keep write permission |

## Verification
Several rules are checked by assertions on every cycle:
- a request held under backpressure stays stable;
- a word-1 read always follows the word-0 read of the same entry;
- a changed-bit write happens only on a store, and a referenced-bit write always carries bit 0 set;
- a hit always shows a valid word 0, and the result strobe lasts one cycle.

Only the bench scenarios can show the rest:
- that the group offsets come from the correct hash and its complement;
- that decoy entries with the wrong secondary flag, wrong tag or a clear valid bit are passed over;
- the exact number of reads per walk;
- the byte values written into memory.

// File: rtl/hpw_pkg.sv
// Package: shared layout constants and state type for the hashed page table walker.
// Assumes 32-bit entry words, big-endian byte numbering inside an entry.
package hpw_pkg;
    localparam int VSID_W    = 24;
    localparam int PGIDX_W   = 16;
    localparam int API_W     = 6;
    localparam int PAGE_BITS = 12;
    localparam int EA_W      = PAGE_BITS + PGIDX_W;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 32;
    localparam int TAG_W     = VSID_W + 1 + API_W;
    localparam int V_BIT     = 31;
    localparam int H_BIT     = 6;
    localparam int R_BIT     = 8;
    localparam int C_BIT     = 7;

    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_W0, S_RD1, S_W1, S_SETR, S_SETC, S_DONE
    } walk_state_e;
endpackage

// File: rtl/hpw_hash.sv
// Module: computes the compare tag and the primary/secondary group offsets.
// Assumes the offset is the hash scaled by the group size, then masked.
module hpw_hash
    import hpw_pkg::*;
#(
    parameter int GROUP_BYTES = 64
) (
    input  logic [VSID_W-1:0]  vsid,
    input  logic [PGIDX_W-1:0] pg_idx,
    input  logic [ADDR_W-1:0]  tbl_mask,
    output logic [TAG_W-1:0]   tag,
    output logic [ADDR_W-1:0]  prim_off,
    output logic [ADDR_W-1:0]  sec_off
);
    localparam int GROUP_SHIFT = $clog2(GROUP_BYTES);

    logic [ADDR_W-1:0] hash;

    // hash, tag and both offsets
    always_comb begin
        hash     = ADDR_W'(vsid) ^ ADDR_W'(pg_idx);
        tag      = {vsid, 1'b0, pg_idx[PGIDX_W-1 -: API_W]};
        prim_off = (hash << GROUP_SHIFT) & tbl_mask;
        sec_off  = ((~hash) << GROUP_SHIFT) & tbl_mask;
    end
endmodule

// File: rtl/hpw_match.sv
// Module: decides whether an entry's first word matches the tag for the current pass.
// Assumes the tag carries 0 in the secondary-flag position.
module hpw_match
    import hpw_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    input  logic [TAG_W-1:0]  tag,
    input  logic              pass,
    output logic              match
);
    logic [TAG_W-1:0] field;

    // valid, pass flag and tag comparison
    always_comb begin
        field = word0[TAG_W-1:0];
        field[H_BIT] = 1'b0;
        match = word0[V_BIT] && (word0[H_BIT] == pass) && (field == tag);
    end
endmodule

// File: rtl/hpw_refchg.sv
// Module: works out the referenced/changed updates and their byte values.
// Assumes byte 6 of an entry is word1[15:8] and byte 7 is word1[7:0].
module hpw_refchg
    import hpw_pkg::*;
(
    input  logic [15:0] word1_lo,
    input  logic        store,
    output logic        need_r,
    output logic        need_c,
    output logic        keep_write,
    output logic [7:0]  r_byte,
    output logic [7:0]  c_byte
);
    // update decisions and byte images
    always_comb begin
        need_r     = !word1_lo[R_BIT];
        need_c     = !word1_lo[C_BIT] && store;
        keep_write = word1_lo[C_BIT] || store;
        r_byte     = word1_lo[15:8] | 8'h01;
        c_byte     = word1_lo[7:0] | 8'h80;
    end
endmodule

// File: rtl/hpw_ctrl.sv
// Module: walk sequencer. Scans both groups, drives the memory port, holds the result.
// Assumes tbl_base/tbl_mask stay stable during a walk and one memory read is outstanding at most.
module hpw_ctrl
    import hpw_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8,
    parameter int ENTRY_BYTES   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  tbl_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PAGE_BITS-1:0] req_pg_off,
    input  logic               req_store,
    input  logic [TAG_W-1:0]   tag_in,
    input  logic [ADDR_W-1:0]  prim_in,
    input  logic [ADDR_W-1:0]  sec_in,
    output logic [TAG_W-1:0]   tag_q,
    output logic               pass_q,
    input  logic               match,
    output logic [15:0]        rc_word,
    output logic               store_q,
    input  logic               need_r,
    input  logic               need_c,
    input  logic               keep_write,
    input  logic [7:0]         r_byte,
    input  logic [7:0]         c_byte,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wbyte,
    input  logic               mem_rvalid,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               done_valid,
    output logic               done_hit,
    output logic [WORD_W-1:0]  done_word0,
    output logic [WORD_W-1:0]  done_word1,
    output logic [ADDR_W-1:0]  done_entry_addr,
    output logic [ADDR_W-1:0]  done_phys_addr,
    output logic               done_write_ok
);
    localparam int IDX_W       = $clog2(GROUP_ENTRIES);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(GROUP_ENTRIES - 1);

    walk_state_e         state_q;
    logic [IDX_W-1:0]    slot_q;
    logic [ADDR_W-1:0]   prim_q, sec_q, grp_off, entry_addr;
    logic [PAGE_BITS-1:0] pg_off_q;
    logic [WORD_W-1:0]   w0_q, w1_q;
    logic                hit_q, wok_q;

    // entry address of the current slot
    always_comb begin
        grp_off    = pass_q ? sec_q : prim_q;
        entry_addr = tbl_base + grp_off + (ADDR_W'(slot_q) << ENTRY_SHIFT);
    end

    // memory request decode from the state
    always_comb begin
        mem_req_valid = (state_q == S_RD0) || (state_q == S_RD1) ||
                        (state_q == S_SETR) || (state_q == S_SETC);
        mem_we        = (state_q == S_SETR) || (state_q == S_SETC);
        mem_wbyte     = (state_q == S_SETC) ? c_byte : r_byte;
        case (state_q)
            S_RD1:   mem_addr = entry_addr + ADDR_W'(4);
            S_SETR:  mem_addr = entry_addr + ADDR_W'(6);
            S_SETC:  mem_addr = entry_addr + ADDR_W'(7);
            default: mem_addr = entry_addr;
        endcase
        rc_word = (state_q == S_W1) ? mem_rdata[15:0] : w1_q[15:0];
    end

    // result ports
    always_comb begin
        req_ready       = (state_q == S_IDLE);
        done_valid      = (state_q == S_DONE);
        done_hit        = hit_q;
        done_word0      = w0_q;
        done_word1      = w1_q;
        done_entry_addr = entry_addr;
        done_phys_addr  = {w1_q[WORD_W-1:PAGE_BITS], pg_off_q};
        done_write_ok   = wok_q;
    end

    // walk state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            slot_q   <= '0;
            pass_q   <= 1'b0;
            tag_q    <= '0;
            prim_q   <= '0;
            sec_q    <= '0;
            pg_off_q <= '0;
            store_q  <= 1'b0;
            w0_q     <= '0;
            w1_q     <= '0;
            hit_q    <= 1'b0;
            wok_q    <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (req_valid) begin
                    tag_q    <= tag_in;
                    prim_q   <= prim_in;
                    sec_q    <= sec_in;
                    pg_off_q <= req_pg_off;
                    store_q  <= req_store;
                    pass_q   <= 1'b0;
                    slot_q   <= '0;
                    state_q  <= S_RD0;
                end
                S_RD0: if (mem_req_ready) state_q <= S_W0;
                S_W0: if (mem_rvalid) begin
                    w0_q <= mem_rdata;
                    if (match) begin
                        state_q <= S_RD1;
                    end else if (slot_q != LAST_SLOT) begin
                        slot_q  <= slot_q + 1'b1;
                        state_q <= S_RD0;
                    end else if (!pass_q) begin
                        pass_q  <= 1'b1;
                        slot_q  <= '0;
                        state_q <= S_RD0;
                    end else begin
                        hit_q   <= 1'b0;
                        wok_q   <= 1'b0;
                        state_q <= S_DONE;
                    end
                end
                S_RD1: if (mem_req_ready) state_q <= S_W1;
                S_W1: if (mem_rvalid) begin
                    w1_q  <= mem_rdata;
                    hit_q <= 1'b1;
                    wok_q <= keep_write;
                    if (need_r)      state_q <= S_SETR;
                    else if (need_c) state_q <= S_SETC;
                    else             state_q <= S_DONE;
                end
                S_SETR: if (mem_req_ready) state_q <= need_c ? S_SETC : S_DONE;
                S_SETC: if (mem_req_ready) state_q <= S_DONE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // checker state: address of the last accepted read
    logic [ADDR_W-1:0] last_rd_q;
    always_ff @(posedge clk) begin
        if (!rst_n) last_rd_q <= '1;
        else if (mem_req_valid && mem_req_ready && !mem_we) last_rd_q <= mem_addr;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
                                           && $stable(mem_we) && $stable(mem_wbyte));
    // R4
    word_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_we && mem_addr[2] |-> last_rd_q == mem_addr - ADDR_W'(4));
    // R7
    chg_store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_we && mem_addr[2:0] == 3'd7 |-> store_q && mem_wbyte[7]);
    // R6
    ref_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_we && mem_addr[2:0] == 3'd6 |-> mem_wbyte[0]);
    // R3
    hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_hit |-> done_word0[V_BIT]);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);
endmodule

// File: rtl/hpw_walker.sv
// Module: top of the hashed page table walker; wires hash, match, update and sequencer.
// Assumes the caller has already chosen the segment and supplies its VSID.
module hpw_walker
    import hpw_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8,
    parameter int ENTRY_BYTES   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       tbl_base,
    input  logic [31:0]       tbl_mask,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [23:0]       req_vsid,
    input  logic [27:0]       req_ea,
    input  logic              req_store,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [7:0]        mem_wbyte,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              done_valid,
    output logic              done_hit,
    output logic [31:0]       done_word0,
    output logic [31:0]       done_word1,
    output logic [31:0]       done_entry_addr,
    output logic [31:0]       done_phys_addr,
    output logic              done_write_ok
);
    localparam int GROUP_BYTES = GROUP_ENTRIES * ENTRY_BYTES;

    logic [TAG_W-1:0]  tag_w, tag_q;
    logic [ADDR_W-1:0] prim_w, sec_w;
    logic              pass_q, match, store_q;
    logic [15:0]       rc_word;
    logic              need_r, need_c, keep_write;
    logic [7:0]        r_byte, c_byte;

    hpw_hash #(.GROUP_BYTES(GROUP_BYTES)) u_hash (
        .vsid(req_vsid), .pg_idx(req_ea[EA_W-1:PAGE_BITS]), .tbl_mask(tbl_mask),
        .tag(tag_w), .prim_off(prim_w), .sec_off(sec_w)
    );

    hpw_match u_match (
        .word0(mem_rdata), .tag(tag_q), .pass(pass_q), .match(match)
    );

    hpw_refchg u_refchg (
        .word1_lo(rc_word), .store(store_q), .need_r(need_r), .need_c(need_c),
        .keep_write(keep_write), .r_byte(r_byte), .c_byte(c_byte)
    );

    hpw_ctrl #(.GROUP_ENTRIES(GROUP_ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_pg_off(req_ea[PAGE_BITS-1:0]), .req_store(req_store),
        .tag_in(tag_w), .prim_in(prim_w), .sec_in(sec_w),
        .tag_q(tag_q), .pass_q(pass_q), .match(match),
        .rc_word(rc_word), .store_q(store_q),
        .need_r(need_r), .need_c(need_c), .keep_write(keep_write),
        .r_byte(r_byte), .c_byte(c_byte),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wbyte(mem_wbyte),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done_valid(done_valid), .done_hit(done_hit),
        .done_word0(done_word0), .done_word1(done_word1),
        .done_entry_addr(done_entry_addr), .done_phys_addr(done_phys_addr),
        .done_write_ok(done_write_ok)
    );
endmodule

// File: tb/tb_hpw_walker.sv
`timescale 1ns/1ps
module tb_hpw_walker;
    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam logic [31:0] MASK = 32'h0000_3FC0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 1'b0, req_store = 1'b0;
    logic [23:0] req_vsid = '0;
    logic [27:0] req_ea = '0;
    logic        req_ready;
    logic        mem_req_valid, mem_we, mem_req_ready;
    logic [31:0] mem_addr, mem_rdata;
    logic [7:0]  mem_wbyte;
    logic        mem_rvalid;
    logic        done_valid, done_hit, done_write_ok;
    logic [31:0] done_word0, done_word1, done_entry_addr, done_phys_addr;

    hpw_walker dut (
        .clk(clk), .rst_n(rst_n), .tbl_base(BASE), .tbl_mask(MASK),
        .req_valid(req_valid), .req_ready(req_ready), .req_vsid(req_vsid),
        .req_ea(req_ea), .req_store(req_store),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wbyte(mem_wbyte),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done_valid(done_valid), .done_hit(done_hit),
        .done_word0(done_word0), .done_word1(done_word1),
        .done_entry_addr(done_entry_addr), .done_phys_addr(done_phys_addr),
        .done_write_ok(done_write_ok)
    );

    int total = 0, bad = 0;

    // memory model
    logic [31:0] mem [0:4095];
    logic        stall_mode = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic        rd_pend = 1'b0;
    logic [1:0]  lat_cnt = '0;
    logic [31:0] rd_addr_q = '0, last_rd = '1;
    int          n_reads = 0, n_writes = 0, order_bad = 0;
    logic [31:0] wr_addr_log [0:3];
    logic [7:0]  wr_data_log [0:3];

    assign mem_req_ready = stall_mode ? lfsr[0] : 1'b1;

    function automatic int widx(input logic [31:0] a);
        return int'((a - BASE) >> 2) & 4095;
    endfunction

    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
    end

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_rvalid <= 1'b0;
        if (rd_pend) begin
            if (lat_cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[widx(rd_addr_q)];
                rd_pend    <= 1'b0;
            end else lat_cnt <= lat_cnt - 1'b1;
        end
        if (mem_req_valid && mem_req_ready) begin
            if (mem_we) begin
                mem[widx(mem_addr)][31 - 8*int'(mem_addr[1:0]) -: 8] <= mem_wbyte;
                if (n_writes < 4) begin
                    wr_addr_log[n_writes] <= mem_addr;
                    wr_data_log[n_writes] <= mem_wbyte;
                end
                n_writes <= n_writes + 1;
            end else begin
                if (mem_addr[2] && (mem_addr - 32'd4 != last_rd)) order_bad <= order_bad + 1;
                last_rd   <= mem_addr;
                rd_pend   <= 1'b1;
                rd_addr_q <= mem_addr;
                lat_cnt   <= stall_mode ? 2'd2 : 2'd0;
                n_reads   <= n_reads + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model from the requirements
    function automatic logic [31:0] hsh(input logic [23:0] v, input logic [27:0] ea);
        return {8'h0, v} ^ {16'h0, ea[27:12]};
    endfunction
    function automatic logic [31:0] grp(input logic [23:0] v, input logic [27:0] ea, input bit sec);
        logic [31:0] h;
        h = hsh(v, ea);
        if (sec) h = ~h;
        return BASE + ((h << 6) & MASK);
    endfunction
    function automatic logic [31:0] mkw0(input logic [23:0] v, input logic [27:0] ea, input bit hflag);
        return {1'b1, v, hflag, ea[27:22]};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    endtask
    task automatic put(input logic [31:0] addr, input logic [31:0] w0, input logic [31:0] w1);
        mem[widx(addr)]     = w0;
        mem[widx(addr) + 1] = w1;
    endtask

    logic got_hit, got_wok;
    logic [31:0] got_w0, got_w1, got_addr, got_pa;

    task automatic walk(input logic [23:0] v, input logic [27:0] ea, input bit st);
        int t;
        @(negedge clk);
        n_reads = 0; n_writes = 0; order_bad = 0;
        req_vsid = v; req_ea = ea; req_store = st; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R9: busy while walking
        chk(req_ready == 1'b0, "R9 busy", 32'(req_ready), 32'h0);
        t = 0;
        while (!done_valid && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(done_valid == 1'b1, "R10 done seen", 32'(done_valid), 32'h1);
        got_hit = done_hit; got_wok = done_write_ok;
        got_w0 = done_word0; got_w1 = done_word1;
        got_addr = done_entry_addr; got_pa = done_phys_addr;
        @(negedge clk);
        // R10: single cycle
        chk(done_valid == 1'b0, "R10 pulse", 32'(done_valid), 32'h0);
        repeat (3) @(negedge clk);
    endtask

    // R2 R3 R4 R8: primary hit at slot 2, mismatched tag at slot 0
    task automatic t_primary(input string tagname);
        logic [23:0] v; logic [27:0] ea; logic [31:0] g, w0, w1;
        v = 24'h00ABCD; ea = 28'h2345_678;
        g = grp(v, ea, 0);
        clear_mem();
        w0 = mkw0(v, ea, 0);
        w1 = 32'h89ABC_000 | 32'h0000_0BAA;
        put(g, w0 ^ 32'h1, w1);
        put(g + 32'd16, w0, w1);
        walk(v, ea, 0);
        chk(got_hit == 1'b1, {"R3 hit ", tagname}, 32'(got_hit), 32'h1);
        chk(got_addr == g + 32'd16, {"R2 entry addr ", tagname}, got_addr, g + 32'd16);
        chk(got_w0 == w0 && got_w1 == w1, {"R8 words ", tagname}, got_w1, w1);
        chk(got_pa == {w1[31:12], ea[11:0]}, {"R8 phys ", tagname}, got_pa, {w1[31:12], ea[11:0]});
        chk(got_wok == 1'b1, {"R8 write ok ", tagname}, 32'(got_wok), 32'h1);
        chk(n_reads == 4, {"R4 read count ", tagname}, 32'(n_reads), 32'd4);
        chk(order_bad == 0, {"R4 order ", tagname}, 32'(order_bad), 32'h0);
        chk(n_writes == 0, {"R6 no write ", tagname}, 32'(n_writes), 32'h0);
    endtask

    // R5 R3: flag decoys, secondary hit at slot 3
    task automatic t_secondary();
        logic [23:0] v; logic [27:0] ea; logic [31:0] p, s, w1;
        v = 24'h3C0F11; ea = 28'h9876_ABC;
        p = grp(v, ea, 0); s = grp(v, ea, 1);
        clear_mem();
        w1 = 32'h12345_180;
        put(p + 32'd8, mkw0(v, ea, 1), w1);
        put(s, mkw0(v, ea, 0), w1);
        put(s + 32'd24, mkw0(v, ea, 1), w1);
        walk(v, ea, 0);
        chk(got_hit == 1'b1, "R5 secondary hit", 32'(got_hit), 32'h1);
        chk(got_addr == s + 32'd24, "R5 secondary addr", got_addr, s + 32'd24);
        chk(n_reads == 13, "R3 flag decoys skipped", 32'(n_reads), 32'd13);
    endtask

    // R5: invalid entry misses both groups
    task automatic t_miss();
        logic [23:0] v; logic [27:0] ea; logic [31:0] w0;
        v = 24'h000777; ea = 28'h0042_000;
        clear_mem();
        w0 = mkw0(v, ea, 0);
        w0[31] = 1'b0;
        put(grp(v, ea, 0), w0, 32'h180);
        walk(v, ea, 1);
        chk(got_hit == 1'b0, "R5 miss", 32'(got_hit), 32'h0);
        chk(n_reads == 16 && n_writes == 0, "R5 miss accesses", 32'(n_reads), 32'd16);
    endtask

    // R6 R7: referenced update on load, then changed update on store, then both
    task automatic t_update();
        logic [23:0] v; logic [27:0] ea; logic [31:0] g, w1, e;
        v = 24'h5A5A00; ea = 28'h1111_222;
        g = grp(v, ea, 0);
        e = g + 32'd40;
        clear_mem();
        w1 = 32'hCAFE0_A2A;
        put(e, mkw0(v, ea, 0), w1);
        walk(v, ea, 0);
        chk(n_writes == 1 && wr_addr_log[0] == e + 32'd6, "R6 R write addr", wr_addr_log[0], e + 32'd6);
        chk(wr_data_log[0] == (w1[15:8] | 8'h01), "R6 R byte", 32'(wr_data_log[0]), 32'(w1[15:8] | 8'h01));
        chk(mem[widx(e) + 1] == (w1 | 32'h100), "R6 memory word", mem[widx(e) + 1], w1 | 32'h100);
        chk(got_wok == 1'b0 && got_w1 == w1, "R7 load drops write", 32'(got_wok), 32'h0);
        walk(v, ea, 1);
        chk(n_writes == 1 && wr_addr_log[0] == e + 32'd7, "R7 C write addr", wr_addr_log[0], e + 32'd7);
        chk(wr_data_log[0] == (w1[7:0] | 8'h80), "R7 C byte", 32'(wr_data_log[0]), 32'(w1[7:0] | 8'h80));
        chk(got_wok == 1'b1, "R7 store keeps write", 32'(got_wok), 32'h1);
        put(e, mkw0(v, ea, 0), w1);
        walk(v, ea, 1);
        chk(n_writes == 2 && wr_addr_log[0] == e + 32'd6 && wr_addr_log[1] == e + 32'd7,
            "R7 R then C", wr_addr_log[1], e + 32'd7);
        chk(mem[widx(e) + 1] == (w1 | 32'h180), "R7 memory word", mem[widx(e) + 1], w1 | 32'h180);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'h1);
        chk(done_valid == 1'b0 && mem_req_valid == 1'b0, "R1 quiet", 32'(mem_req_valid), 32'h0);
        t_primary("fast");
        t_secondary();
        t_miss();
        t_update();
        // R9: back-pressure and slow read data
        stall_mode = 1'b1;
        t_primary("R9 stalled");
        t_update();
        stall_mode = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule